// File: doc/BRIEF.md
# Split/Unify Threading Mode Controller

This controller sits beside an array that can run either as one full-width array or as two half-width partitions. Each cycle it compares the program counter of each partition with two programmable addresses: a split point and a unify point. When the primary partition reaches the split point, the controller switches the array into dual-threaded mode. It then runs a short stack-pointer preparation phase for the second thread, and lets both partitions run on their own.

In dual-threaded mode, each partition that reaches the unify point is marked as joined. The first partition to join is halted until the other one arrives. When both have joined, the array goes back to single-threaded mode and all halts are released.

Software sets the split address, the unify address and the length of the preparation phase before the program starts. The `run` input marks that the program is executing.

Top module: `thread_mode_ctrl`

## Requirements
- R1: After reset, `thread_mode`, `halt_a`, `halt_b` and `sp_load` are all low and the controller is in single-threaded mode.
- R2: A configuration write with `cfg_we` high takes effect only while the controller is in single-threaded mode and `run` is low. `cfg_sel` selects the target: 0 = split address, 1 = unify address, 2 = preparation length (low `CW` bits of `cfg_wdata`). A write at any other time, or with `cfg_sel` = 3, has no effect.
- R3: In single-threaded mode with `run` high, a cycle where `pc_a_vld` is high and `pc_a` equals the split address raises `thread_mode` on the next cycle. `pc_b` is not compared in this mode.
- R4: Dual-threaded mode starts with a preparation phase that lasts max(length, 1) cycles. `sp_load` is high for exactly its first cycle. `halt_b` is high and `halt_a` is low throughout the phase.
- R5: After the preparation phase, a cycle where exactly one partition presents the unify address with its valid flag high raises that partition's halt on the next cycle, while the other partition keeps running.
- R6: A halted partition stays halted until the other partition presents the unify address. On the next cycle `thread_mode` and both halts are low.
- R7: If both partitions present the unify address in the same cycle, the controller returns directly to single-threaded mode and raises no halt.
- R8: The joined marks are cleared on entry to the running dual phase. A unify address seen during the preparation phase has no effect.
- R9: A PC whose valid flag is low never matches the split or unify address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Program executing; blocks configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | AW | Configuration write data |
| pc_a | input | AW | Program counter of the primary partition |
| pc_a_vld | input | 1 | `pc_a` is valid this cycle |
| pc_b | input | AW | Program counter of the second partition |
| pc_b_vld | input | 1 | `pc_b` is valid this cycle |
| thread_mode | output | 1 | Dual-threaded enable toward the merger and bypass network |
| halt_a | output | 1 | Hold the primary partition |
| halt_b | output | 1 | Hold the second partition |
| sp_load | output | 1 | One-cycle pulse that loads the second thread's stack pointer |

## Verification
The assertions assume three things about the inputs. A halted partition keeps presenting the unify address. Configuration is written only with `run` low. Split entry is raised only by the primary partition's counter.

The stimulus follows these assumptions. Each partition's PC stays at the unify address once it has joined. Every configuration phase runs with `run` low, apart from the deliberate ignored-write probes. Those probes are checked only through their effect on the outputs.

// File: rtl/thread_mode_ctrl.sv
module thread_mode_ctrl #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int INIT_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [AW-1:0] pc_a,
  input  logic          pc_a_vld,
  input  logic [AW-1:0] pc_b,
  input  logic          pc_b_vld,
  output logic          thread_mode,
  output logic          halt_a,
  output logic          halt_b,
  output logic          sp_load
);

  typedef enum logic [1:0] {ST_SINGLE, ST_PREP, ST_DUAL, ST_WAIT} st_t;

  st_t            st;
  logic [AW-1:0]  split_q, unify_q;
  logic [CW-1:0]  len_q, cnt;
  logic           join_a, join_b;

  wire cfg_ok   = cfg_we && !run && st == ST_SINGLE;
  wire hit_spl  = run && pc_a_vld && pc_a == split_q;
  wire hit_ua   = pc_a_vld && pc_a == unify_q;
  wire hit_ub   = pc_b_vld && pc_b == unify_q;
  wire [CW:0] len_eff = (len_q == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, len_q};
  wire        prep_done = ({1'b0, cnt} + 1'b1) >= len_eff;
  wire        other_hit = join_a ? hit_ub : hit_ua;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_q <= '0;
      unify_q <= '0;
      len_q   <= CW'(INIT_LEN);
    end else if (cfg_ok) begin
      case (cfg_sel)
        2'd0: split_q <= cfg_wdata;
        2'd1: unify_q <= cfg_wdata;
        2'd2: len_q   <= cfg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_SINGLE;
      cnt    <= '0;
      join_a <= 1'b0;
      join_b <= 1'b0;
    end else begin
      case (st)
        ST_SINGLE: if (hit_spl) begin
          st  <= ST_PREP;
          cnt <= '0;
        end
        ST_PREP: if (prep_done) begin
          st     <= ST_DUAL;
          join_a <= 1'b0;
          join_b <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_DUAL: begin
          if (hit_ua && hit_ub) st <= ST_SINGLE;
          else if (hit_ua || hit_ub) begin
            st     <= ST_WAIT;
            join_a <= hit_ua;
            join_b <= hit_ub;
          end
        end
        ST_WAIT: if (other_hit) begin
          st     <= ST_SINGLE;
          join_a <= 1'b0;
          join_b <= 1'b0;
        end
        default: st <= ST_SINGLE;
      endcase
    end
  end

  assign thread_mode = st != ST_SINGLE;
  assign sp_load     = st == ST_PREP && cnt == '0;
  assign halt_a      = st == ST_WAIT && join_a;
  assign halt_b      = st == ST_PREP || (st == ST_WAIT && join_b);

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> !thread_mode && !halt_a && !halt_b); // R1
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (run || thread_mode) |=> $stable(split_q) && $stable(unify_q) && $stable(len_q)); // R2
  AST_SPLIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!thread_mode && hit_spl) |=> thread_mode && sp_load); // R3
  AST_SPLOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> !sp_load); // R4
  AST_PREP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |-> halt_b && !halt_a); // R4
  AST_ONE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_a && halt_b)); // R5
  AST_HALT_IN_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_a || halt_b) |-> thread_mode); // R6
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_a && !hit_ub) |=> halt_a); // R6
  AST_JOIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_a && hit_ub) |=> !thread_mode && !halt_a && !halt_b); // R6
  AST_SAME_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DUAL && hit_ua && hit_ub) |=> !thread_mode && !halt_a && !halt_b); // R7
  AST_DUAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PREP && prep_done) |=> !join_a && !join_b); // R8
  AST_INVALID_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (!thread_mode && !pc_a_vld) |=> !thread_mode); // R9

endmodule

// File: tb/thread_mode_ctrl_test.sv
module thread_mode_ctrl_test;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0, run = 0, cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [AW-1:0] cfg_wdata = 0, pc_a = 0, pc_b = 0;
  logic pc_a_vld = 0, pc_b_vld = 0;
  logic thread_mode, halt_a, halt_b, sp_load;

  always #10 clk = ~clk;

  thread_mode_ctrl #(.AW(AW), .CW(8), .INIT_LEN(4)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pc_a(pc_a), .pc_a_vld(pc_a_vld), .pc_b(pc_b),
    .pc_b_vld(pc_b_vld), .thread_mode(thread_mode), .halt_a(halt_a),
    .halt_b(halt_b), .sp_load(sp_load));

  int checks = 0, errors = 0;
  string req = "R1";

  // behavioural model: mode 0 single, 1 prep, 2 dual, 3 wait
  int m_mode, m_k, m_spl, m_uni, m_len;
  bit m_ja, m_jb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_k = 0; m_spl = 0; m_uni = 0; m_len = 4; m_ja = 0; m_jb = 0;
    end else begin
      bit ua, ub;
      ua = pc_a_vld && pc_a == m_uni;
      ub = pc_b_vld && pc_b == m_uni;
      if (cfg_we && !run && m_mode == 0) begin
        if (cfg_sel == 0) m_spl = cfg_wdata;
        if (cfg_sel == 1) m_uni = cfg_wdata;
        if (cfg_sel == 2) m_len = cfg_wdata % 256;
      end
      case (m_mode)
        0: if (run && pc_a_vld && pc_a == m_spl) begin m_mode = 1; m_k = 0; end
        1: begin
             m_k++;
             if (m_k >= (m_len == 0 ? 1 : m_len)) begin m_mode = 2; m_ja = 0; m_jb = 0; end
           end
        2: if (ua && ub) m_mode = 0;
           else if (ua || ub) begin m_mode = 3; m_ja = ua; m_jb = ub; end
        default: if ((m_ja && ub) || (m_jb && ua)) begin m_mode = 0; m_ja = 0; m_jb = 0; end
      endcase
    end
  end

  task automatic chk(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("thread_mode", thread_mode, m_mode != 0);
    chk("halt_a", halt_a, m_mode == 3 && m_ja);
    chk("halt_b", halt_b, m_mode == 1 || (m_mode == 3 && m_jb));
    chk("sp_load", sp_load, m_mode == 1 && m_k == 0);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic cfg(int sel, int val);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = AW'(val);
    cyc(1);
    cfg_we = 0;
  endtask

  bit done = 0;
  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    req = "R1";
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk("reset thread_mode R1", thread_mode, 1'b0);

    req = "R2";
    cfg(0, 'h40); cfg(1, 'h80); cfg(2, 3); cfg(3, 'h40);
    run = 1;
    cfg(0, 'h10);            // ignored: run high
    pc_a = 'h10; pc_a_vld = 1;
    cyc(3);
    chk("no split at rejected address R2", thread_mode, 1'b0);

    req = "R9";
    pc_a = 'h40; pc_a_vld = 0;
    cyc(3);
    req = "R3";
    pc_b = 'h40; pc_b_vld = 1; pc_a = 'h0; pc_a_vld = 1;
    cyc(2);
    pc_a = 'h40;
    cyc(1);
    chk("split entered R3", thread_mode, 1'b1);

    req = "R8";
    pc_a = 'h80; pc_b = 'h80;   // unify seen during prep: no effect
    cyc(2);
    req = "R4";
    pc_a = 'h44; pc_b = 'h200;
    cfg(0, 'h99);               // ignored: dual mode
    cyc(2);

    req = "R5";
    pc_a = 'h80;
    cyc(2);
    chk("halt_a after first join R5", halt_a, 1'b1);
    req = "R6";
    pc_b = 'h210; pc_b_vld = 0;
    cyc(4);
    pc_b = 'h80; pc_b_vld = 1;
    cyc(1);
    chk("exit after second join R6", thread_mode, 1'b0);
    pc_a = 'h0; pc_b = 'h0;
    cyc(2);

    req = "R7";
    pc_a = 'h40;
    cyc(1);
    pc_a = 'h41; pc_b = 'h300;
    cyc(3);
    pc_a = 'h80; pc_b = 'h80;
    cyc(1);
    chk("same-cycle join halts R7", halt_a | halt_b, 1'b0);
    pc_a = 'h0; pc_b = 'h0;
    cyc(2);

    req = "R4";
    run = 0;
    cfg(2, 0);
    run = 1;
    pc_a = 'h40;
    cyc(1);
    pc_a = 'h50;
    cyc(1);
    req = "R5";
    pc_b = 'h80;
    cyc(2);
    chk("halt_b after b joins R5", halt_b, 1'b1);
    req = "R6";
    cyc(2);
    pc_a = 'h80;
    cyc(2);
    pc_a = 'h0; pc_b = 'h0;
    cyc(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule